// File: doc/BRIEF.md
# Two-Channel DMA Bus Arbiter

This block decides, clock by clock, who drives a shared memory bus: DMA channel 0, DMA channel 1, or the CPU. Each channel presents a request, a mode bit and a completion strobe. The block answers with a registered grant per channel and a flag that tells the CPU it owns the bus. Address generation, data movement and register decoding live elsewhere. This block only issues grants and remembers whose turn comes next.

A channel in burst mode keeps the bus until it signals completion or withdraws its request. A channel in cycle-steal mode gets exactly one bus cycle (one byte) per grant. After each such byte the CPU keeps the bus for a fixed window before any channel may be granted again. Channel 0 wins every contest. When both channels steal cycles, they alternate byte by byte. A burst channel 1 stays locked out for as long as channel 0 is requesting.

Top module: `dma_pair_arbiter`

## Requirements
- R1: At most one bit of `grant` is high in any cycle, and `cpu_own` is high exactly when no grant bit is high.
- R2: After reset no grant is asserted, `cpu_own` is high, the CPU window is closed, and the alternation pointer favours channel 0. The first contest between two cycle-steal channels therefore goes to channel 0.
- R3: When both channels request while the bus is idle and at least one of them is in burst mode (`mode` bit = 1), channel 0 is granted.
- R4: A burst grant stays asserted while its channel keeps `req` high and `done` low. The cycle in which `done` is sampled high is the last granted cycle. Dropping `req` releases the grant on the next clock edge.
- R5: A channel 1 burst grant is released on the next clock edge once channel 0 raises its request, and channel 0 is granted one cycle later.
- R6: A cycle-steal grant (`mode` bit = 0) lasts exactly one clock cycle.
- R7: After every cycle-steal grant, `grant` stays 0 for exactly GAP cycles (default 8). A grant may appear in the cycle after that.
- R8: With both channels requesting in cycle-steal mode, grants alternate 0, 1, 0, 1, with the CPU window between each pair.
- R9: With channel 0 in cycle-steal mode and channel 1 in burst mode, channel 1 receives no grant while channel 0 is requesting. Once channel 0 stops requesting, channel 1 is granted after the current CPU window and then keeps the bus.
- R10: A channel that is the only one requesting in cycle-steal mode still gets the GAP-cycle CPU window between its bytes.
- R11: From an idle bus with the window closed, a request sampled on a clock edge is granted on the next edge. After a burst grant is released, one CPU cycle passes before the next grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 2 | Transfer request per channel |
| mode | input | 2 | Per channel: 1 = burst, 0 = cycle-steal |
| done | input | 2 | Per channel: last byte of the block in this cycle |
| grant | output | 2 | Registered bus grant per channel |
| cpu_own | output | 1 | High when no channel holds the bus |

## Verification
The bench counts the CPU window exactly. If the counter were off by one, the second cycle-steal grant would appear a cycle early or late. It runs two cycle-steal channels for several rounds, so a design that forgot to flip the turn pointer would grant channel 0 twice in a row. A cycle-steal channel 0 is paired with a burst channel 1, which exposes any design that lets the burst channel slip into a CPU window. Preemption and completion of bursts are also driven: a design that ignored `done`, or let channel 1 keep the bus against channel 0, would show a grant held one cycle too long.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
    localparam int NCH = 2;
    localparam logic MODE_STEAL = 1'b0;
    localparam logic MODE_BURST = 1'b1;

    typedef struct packed {
        logic [NCH-1:0] grant;
        logic           burst;
        logic           turn;   // 1: channel 1 is next in cycle-steal rotation
    } arb_state_t;
endpackage

// File: rtl/dma_gap_timer.sv
module dma_gap_timer #(
    parameter int GAP = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic open
);
    localparam int CW = (GAP > 2) ? $clog2(GAP) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(GAP - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = RELOAD;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign open = (cnt_q == '0);
endmodule

// File: rtl/dma_pick.sv
module dma_pick
    import dma_arb_pkg::*;
(
    input  logic [NCH-1:0] req,
    input  logic [NCH-1:0] mode,
    input  logic           turn,
    output logic [NCH-1:0] pick
);
    always_comb begin
        if (req == 2'b11) begin
            if (mode[0] == MODE_BURST || mode[1] == MODE_BURST)
                pick = 2'b01;
            else
                pick = turn ? 2'b10 : 2'b01;
        end else begin
            pick = req;
        end
    end
endmodule

// File: rtl/dma_pair_arbiter.sv
module dma_pair_arbiter
    import dma_arb_pkg::*;
#(
    parameter int GAP = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] req,
    input  logic [1:0] mode,
    input  logic [1:0] done,
    output logic [1:0] grant,
    output logic       cpu_own
);
    arb_state_t state_d, state_q;
    logic [NCH-1:0] pick;
    logic gap_open, gap_load, hold0, hold1;
    logic burst_q;

    dma_pick u_pick (
        .req  (req),
        .mode (mode),
        .turn (state_q.turn),
        .pick (pick)
    );

    dma_gap_timer #(.GAP(GAP)) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (gap_load),
        .open  (gap_open)
    );

    always_comb begin
        state_d  = state_q;
        gap_load = 1'b0;
        hold0 = state_q.grant[0] && state_q.burst && req[0] && !done[0];
        hold1 = state_q.grant[1] && state_q.burst && req[1] && !done[1] && !req[0];
        if (|state_q.grant) begin
            if (!(hold0 || hold1)) begin
                state_d.grant = '0;
                state_d.turn  = state_q.grant[0];
                gap_load      = !state_q.burst;
            end
        end else if (gap_open && (|pick)) begin
            state_d.grant = pick;
            state_d.burst = |(pick & mode);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign grant   = state_q.grant;
    assign cpu_own = ~|state_q.grant;
    assign burst_q = state_q.burst;
endmodule

// File: rtl/dma_pair_arbiter_chk.sv
module dma_pair_arbiter_chk #(
    parameter int GAP = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] req,
    input logic [1:0] grant,
    input logic       cpu_own,
    input logic       burst_q
);
    localparam int WW = $clog2(GAP + 1);
    logic [WW-1:0] win;

    always_ff @(posedge clk) begin
        if (!rst_n)                  win <= '0;
        else if (|grant && !burst_q) win <= WW'(GAP);
        else if (win != '0)          win <= win - 1'b1;
    end

    assert_one_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    assert_cpu_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_own == (grant == 2'b00));
    assert_req_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (grant[0] && !req[0]) |=> !grant[0]);
    assert_preempt_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (grant[1] && req[0]) |=> !grant[1]);
    assert_single_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant && !burst_q) |=> (grant == 2'b00));
    assert_cpu_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (win != '0) |-> (grant == 2'b00));
endmodule

bind dma_pair_arbiter dma_pair_arbiter_chk #(.GAP(GAP)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .grant   (grant),
    .cpu_own (cpu_own),
    .burst_q (burst_q)
);

// File: tb/sim_dma_pair_arbiter.sv
module sim_dma_pair_arbiter;
    localparam int GAP = 8;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] req = '0, mode = '0, done = '0;
    logic [1:0] grant;
    logic cpu_own;
    int vectors = 0, miscompares = 0;

    always #10 clk = ~clk;

    dma_pair_arbiter #(.GAP(GAP)) u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .mode(mode), .done(done),
        .grant(grant), .cpu_own(cpu_own)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string tag, logic [1:0] exp);
        vectors++;
        if (grant !== exp || cpu_own !== (exp == 2'b00)) begin
            miscompares++;
            $display("FAIL %s: grant=%b cpu_own=%b expected grant=%b cpu_own=%b",
                     tag, grant, cpu_own, exp, exp == 2'b00);
        end
    endtask

    task automatic do_reset();
        req = '0; mode = '0; done = '0;
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
    endtask

    task automatic window(string tag);
        for (int i = 0; i < GAP; i++) begin
            tick();
            check(tag, 2'b00);
        end
    endtask

    task automatic t_reset();
        do_reset();
        check("R2 reset", 2'b00);
        tick();
        check("R2 idle after reset", 2'b00);
    endtask

    task automatic t_alternate();
        do_reset();
        mode = 2'b00; req = 2'b11;
        tick(); check("R2 R11 first steal to ch0", 2'b01);
        window("R6 R7 window after ch0");
        tick(); check("R8 ch1 turn", 2'b10);
        window("R7 window after ch1");
        tick(); check("R8 ch0 turn again", 2'b01);
        window("R7 window");
        tick(); check("R8 ch1 turn again", 2'b10);
        req = 2'b00;
        window("R7 final window");
    endtask

    task automatic t_burst0();
        do_reset();
        mode = 2'b01; req = 2'b11;
        tick(); check("R3 ch0 burst wins", 2'b01);
        for (int i = 0; i < 5; i++) begin
            tick(); check("R4 burst held", 2'b01);
        end
        done = 2'b01;
        tick(); check("R4 released after done", 2'b00);
        done = 2'b00; req = 2'b10;
        tick(); check("R11 ch1 after burst gap", 2'b10);
        tick(); check("R6 steal one cycle", 2'b00);
        req = 2'b00;
        window("R7 window after ch1 byte");
    endtask

    task automatic t_both_burst();
        do_reset();
        mode = 2'b11; req = 2'b11;
        tick(); check("R3 both burst ch0", 2'b01);
        req = 2'b10;
        tick(); check("R4 req drop release", 2'b00);
        tick(); check("R11 ch1 burst start", 2'b10);
        tick(); check("R4 ch1 burst held", 2'b10);
        req = 2'b11;
        tick(); check("R5 ch1 preempted", 2'b00);
        tick(); check("R5 ch0 granted", 2'b01);
        req = 2'b00;
        tick(); check("R4 ch0 released", 2'b00);
    endtask

    task automatic t_steal_vs_burst();
        do_reset();
        mode = 2'b10; req = 2'b11;
        tick(); check("R9 ch0 steal first", 2'b01);
        window("R9 window no ch1");
        tick(); check("R9 ch0 again not ch1", 2'b01);
        req = 2'b10;
        window("R9 window before ch1");
        tick(); check("R9 ch1 burst after ch0", 2'b10);
        tick(); check("R9 ch1 burst held", 2'b10);
        done = 2'b10;
        tick(); check("R4 ch1 done", 2'b00);
        done = 2'b00; req = 2'b00;
    endtask

    task automatic t_lone();
        do_reset();
        mode = 2'b00; req = 2'b10;
        tick(); check("R10 lone ch1", 2'b10);
        window("R10 lone window");
        tick(); check("R10 lone ch1 second byte", 2'b10);
        window("R10 lone window 2");
        req = 2'b00;
        tick(); check("R10 idle", 2'b00);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        t_reset();
        t_alternate();
        t_burst0();
        t_both_burst();
        t_steal_vs_burst();
        t_lone();
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        vectors++; miscompares++;
        $display("FAIL watchdog R1: run hung, actual=timeout expected=finish");
        summary();
    end
endmodule